// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block sits on the slave side of an SPI link and answers the identification and status-read commands of a serial NOR flash. It has no memory array. It samples the SPI mode 0 lines (serial clock, active-low chip select and the master's data line) with the local clock. It collects the opcode and any later bytes, and it drives the slave data line with the reply that each command defines. The manufacturer code, the memory type, the device code and the status bits come in on static configuration ports. The write-enable latch is the one piece of status that the block holds itself.

The three serial inputs pass through a synchronizer of configurable depth, and the edges of the serial clock are detected after that synchronizer. Incoming data is taken on the rising edge of the serial clock. The reply shifts out most significant bit first and changes after each falling edge. The first bit of a reply byte is set up on the falling edge that closes the previous byte. The output enable is low whenever the block has nothing to return. This covers chip select high, the opcode byte, the dummy and selector bytes, and commands that have no reply.

Top module: `spi_id_responder`

## Requirements
- R1: After opcode 0x9F, reply bytes 1, 2 and 3 of the frame (byte 0 being the opcode) carry `mfr_id_i`, `mem_type_i` and `dev_id_i` in that order.
- R2: After opcode 0x90, bytes 1 to 3 come from the master and byte 3 is the order selector. When the selector is 0x00, reply byte 4 is `mfr_id_i` and byte 5 is `dev_id_i`.
- R3: After opcode 0x90 with any nonzero selector (0x01 included), reply byte 4 is `dev_id_i` and byte 5 is `mfr_id_i`.
- R4: After opcode 0xAB, bytes 1 to 3 are dummies from the master and reply byte 4 (the fifth byte of the frame) is `dev_id_i`.
- R5: After opcode 0x05, every byte from byte 1 onward carries the status byte for as long as chip select stays low. Bit 1 of that byte is the internal write-enable latch. Bits 7:2 and bit 0 are taken from `status_i`, and `status_i[1]` is ignored.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either one acts only when chip select rises after exactly 8 serial clock rising edges.
- R7: A 0x06 or 0x04 frame with any bit count other than 8 (for example 7, 9 or 16) leaves the write-enable latch unchanged.
- R8: Reading past the last defined reply byte returns 0xFF: byte 4 and later for 0x9F, byte 6 and later for 0x90, and byte 5 and later for 0xAB.
- R9: `miso_oe_o` is low, and `miso_o` is 0, in the following cases: chip select high, during the opcode byte, during the dummy and selector bytes of 0x90 and 0xAB, and for 0x06, 0x04 and any unlisted opcode.
- R10: The reply shifts out MSB first. `miso_o` and `miso_oe_o` change only SYNC_STAGES+1 local clock cycles after a falling serial clock edge or a chip select change, and at no other time.
- R11: After reset `miso_oe_o` is low and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, idles low (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| mfr_id_i | input | 8 | Manufacturer code returned by the ID commands |
| mem_type_i | input | 8 | Memory type code returned by 0x9F |
| dev_id_i | input | 8 | Device code returned by the ID commands |
| status_i | input | 8 | Status bits; bit 1 is replaced by the internal latch |
| miso_o | output | 1 | Serial reply data, 0 while not driven |
| miso_oe_o | output | 1 | Drive enable for the reply line |

## Verification
The hardest case to reach from the ports is the write-enable latch, because a frame must end with chip select rising exactly on a byte boundary. The bench sends write-enable and write-disable frames of 7, 8, 9 and 16 bits. After each one it reads the status register, so the latch state shows up at bit 1 of the reply. The order-selector command is run with both selector values, and every ID command is clocked past its last defined byte. A behavioural model, delayed by the synchronizer latency, is compared against the data and enable lines on every clock. This pins down the falling-edge timing and the high-impedance windows during the dummy bytes.

// File: rtl/spi_idr_pkg.sv
package spi_idr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] WEL_MASK  = 8'h02;

  typedef enum logic [BYTE_W-1:0] {
    OP_JEDEC_ID = 8'h9F,
    OP_ID_ORDER = 8'h90,
    OP_SIG      = 8'hAB,
    OP_RD_STAT  = 8'h05,
    OP_WR_EN    = 8'h06,
    OP_WR_DIS   = 8'h04
  } opcode_e;

endpackage

// File: rtl/spi_idr_sync.sv
module spi_idr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic mosi_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o
);

  localparam int unsigned W = 3;
  localparam logic [W-1:0] IDLE = 3'b100; // {cs_n, sck, mosi}

  logic [W-1:0] raw;
  logic [W-1:0] last;
  logic         sck_d, cs_d;

  assign raw = {cs_ni, sck_i, mosi_i};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= IDLE;
        else         q <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= IDLE;
        else         q <= g_stage[g-1].q;
      end
    end
  end

  assign last = g_stage[STAGES-1].q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= last[1];
      cs_d  <= last[2];
    end
  end

  assign cs_n_o     = last[2];
  assign mosi_o     = last[0];
  assign sck_rise_o = last[1] & ~sck_d;
  assign sck_fall_o = ~last[1] & sck_d;
  assign cs_rise_o  = last[2] & ~cs_d;

endmodule

// File: rtl/spi_idr_shift.sv
module spi_idr_shift import spi_idr_pkg::*; #(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_rise_i,
  input  logic              mosi_i,
  output logic [BIT_W-1:0]  bit_cnt_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              byte_end_o,
  output logic [BYTE_W-1:0] rx_byte_o
);

  localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-2:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      idx_q <= '0;
      rx_q  <= '0;
    end else if (cs_n_i) begin
      bit_q <= '0;
      idx_q <= '0;
      rx_q  <= '0;
    end else if (sck_rise_i) begin
      rx_q  <= {rx_q[BYTE_W-3:0], mosi_i};
      bit_q <= bit_q + BIT_W'(1);
      if (bit_q == BIT_LAST && idx_q != IDX_MAX) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign bit_cnt_o  = bit_q;
  assign byte_idx_o = idx_q;
  assign byte_end_o = ~cs_n_i & sck_rise_i & (bit_q == BIT_LAST);
  assign rx_byte_o  = {rx_q, mosi_i};

  // byte index saturates; only chip select brings it back to zero
  p_idx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == IDX_MAX && !cs_n_i) |=> (idx_q == IDX_MAX));

endmodule

// File: rtl/spi_idr_reply.sv
module spi_idr_reply import spi_idr_pkg::*; #(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic              byte_end_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [BIT_W-1:0]  bit_cnt_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] mfr_id_i,
  input  logic [BYTE_W-1:0] mem_type_i,
  input  logic [BYTE_W-1:0] dev_id_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] reply_o,
  output logic              reply_oe_o
);

  localparam logic [IDX_W-1:0] IDX_OP  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_B1  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_B2  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_B3  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_B4  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_B5  = IDX_W'(5);

  logic [BYTE_W-1:0] opcode_q;
  logic              mfr_first_q;
  logic              wel_q;
  logic [BYTE_W-1:0] stat_byte;
  logic [BYTE_W-1:0] first_id, second_id;
  logic              single_byte_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q    <= '0;
      mfr_first_q <= 1'b1;
    end else if (byte_end_i) begin
      if (byte_idx_i == IDX_OP) opcode_q    <= rx_byte_i;
      if (byte_idx_i == IDX_B3) mfr_first_q <= (rx_byte_i == '0);
    end
  end

  // latch commands count only when the frame is exactly one whole byte
  assign single_byte_end = cs_rise_i && byte_idx_i == IDX_B1 && bit_cnt_i == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (single_byte_end) begin
      if (opcode_q == OP_WR_EN)       wel_q <= 1'b1;
      else if (opcode_q == OP_WR_DIS) wel_q <= 1'b0;
    end
  end

  assign stat_byte = (status_i & ~WEL_MASK) | (wel_q ? WEL_MASK : '0);
  assign first_id  = mfr_first_q ? mfr_id_i : dev_id_i;
  assign second_id = mfr_first_q ? dev_id_i : mfr_id_i;

  always_comb begin
    reply_o    = FILL_BYTE;
    reply_oe_o = 1'b0;
    case (opcode_q)
      OP_JEDEC_ID: begin
        reply_oe_o = 1'b1;
        if (byte_idx_i == IDX_B1)      reply_o = mfr_id_i;
        else if (byte_idx_i == IDX_B2) reply_o = mem_type_i;
        else if (byte_idx_i == IDX_B3) reply_o = dev_id_i;
      end
      OP_ID_ORDER: begin
        reply_oe_o = (byte_idx_i >= IDX_B4);
        if (byte_idx_i == IDX_B4)      reply_o = first_id;
        else if (byte_idx_i == IDX_B5) reply_o = second_id;
      end
      OP_SIG: begin
        reply_oe_o = (byte_idx_i >= IDX_B4);
        if (byte_idx_i == IDX_B4) reply_o = dev_id_i;
      end
      OP_RD_STAT: begin
        reply_oe_o = 1'b1;
        reply_o    = stat_byte;
      end
      default: begin
        reply_oe_o = 1'b0;
        reply_o    = FILL_BYTE;
      end
    endcase
  end

  p_wel_at_cs_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(wel_q));

  p_no_reply_dummy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opcode_q == OP_ID_ORDER || opcode_q == OP_SIG) && byte_idx_i < IDX_B4) |-> !reply_oe_o);

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder import spi_idr_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] mfr_id_i,
  input  logic [BYTE_W-1:0] mem_type_i,
  input  logic [BYTE_W-1:0] dev_id_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              miso_o,
  output logic              miso_oe_o
);

  logic              cs_n_s, mosi_s, sck_rise, sck_fall, cs_rise;
  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic              byte_end;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] reply;
  logic              reply_oe;
  logic              at_boundary;
  logic [BYTE_W-1:0] tx_q;
  logic              oe_q;

  spi_idr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .mosi_i     (mosi_i),
    .cs_n_o     (cs_n_s),
    .mosi_o     (mosi_s),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_rise_o  (cs_rise)
  );

  spi_idr_shift #(.IDX_W(IDX_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_s),
    .sck_rise_i (sck_rise),
    .mosi_i     (mosi_s),
    .bit_cnt_o  (bit_cnt),
    .byte_idx_o (byte_idx),
    .byte_end_o (byte_end),
    .rx_byte_o  (rx_byte)
  );

  spi_idr_reply #(.IDX_W(IDX_W)) u_reply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_rise_i  (cs_rise),
    .byte_end_i (byte_end),
    .byte_idx_i (byte_idx),
    .bit_cnt_i  (bit_cnt),
    .rx_byte_i  (rx_byte),
    .mfr_id_i   (mfr_id_i),
    .mem_type_i (mem_type_i),
    .dev_id_i   (dev_id_i),
    .status_i   (status_i),
    .reply_o    (reply),
    .reply_oe_o (reply_oe)
  );

  // falling edge that closes a byte sets up the first bit of the next one
  assign at_boundary = (bit_cnt == '0) && (byte_idx != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else if (cs_n_s) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else if (sck_fall) begin
      if (at_boundary) begin
        tx_q <= reply;
        oe_q <= reply_oe;
      end else begin
        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o    = oe_q & tx_q[BYTE_W-1];
  assign miso_oe_o = oe_q;

  p_oe_off_deselect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !miso_oe_o);

  p_opcode_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_s && byte_idx == '0) |-> !miso_oe_o);

  p_hold_between_falls_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_n_s) |=> $stable({miso_oe_o, miso_o}));

endmodule

// File: tb/spi_id_responder_tb.sv
module spi_id_responder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int HALF       = 6;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck_r = 1'b0, cs_nr = 1'b1, mosi_r = 1'b0;
  logic [7:0] mfr_r = 8'hC2, type_r = 8'h20, dev_r = 8'h17, status_r = 8'h00;
  logic       miso_o, miso_oe_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_id_responder #(.SYNC_STAGES(SYNC), .IDX_W(3)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sck_i      (sck_r),
    .cs_ni      (cs_nr),
    .mosi_i     (mosi_r),
    .mfr_id_i   (mfr_r),
    .mem_type_i (type_r),
    .dev_id_i   (dev_r),
    .status_i   (status_r),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o)
  );

  // ---------------- behavioural reference ----------------
  logic       h_sck [SYNC+2];
  logic       h_cs  [SYNC+2];
  logic       h_mosi[SYNC+2];
  int         m_bits, m_idx;
  logic [7:0] m_rx, m_tx;
  logic       m_oe, m_wel;
  logic [7:0] m_bytes [16];

  function automatic logic [8:0] ref_reply(int k);
    logic [7:0] op;
    logic [7:0] st;
    logic [7:0] a, b;
    op = m_bytes[0];
    st = {status_r[7:2], m_wel, status_r[0]};
    a  = (m_bytes[3] == 8'h00) ? mfr_r : dev_r;
    b  = (m_bytes[3] == 8'h00) ? dev_r : mfr_r;
    case (op)
      8'h9F: return {1'b1, (k == 1) ? mfr_r : (k == 2) ? type_r : (k == 3) ? dev_r : 8'hFF};
      8'h90: return (k < 4) ? 9'h0FF : {1'b1, (k == 4) ? a : (k == 5) ? b : 8'hFF};
      8'hAB: return (k < 4) ? 9'h0FF : {1'b1, (k == 4) ? dev_r : 8'hFF};
      8'h05: return {1'b1, st};
      default: return 9'h0FF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC+2; i++) begin
        h_sck[i] = 1'b0; h_cs[i] = 1'b1; h_mosi[i] = 1'b0;
      end
      m_bits = 0; m_idx = 0; m_rx = 8'h00; m_tx = 8'h00; m_oe = 1'b0; m_wel = 1'b0;
      for (int i = 0; i < 16; i++) m_bytes[i] = 8'h00;
    end else begin
      for (int i = SYNC+1; i > 0; i--) begin
        h_sck[i] = h_sck[i-1]; h_cs[i] = h_cs[i-1]; h_mosi[i] = h_mosi[i-1];
      end
      h_sck[0] = sck_r; h_cs[0] = cs_nr; h_mosi[0] = mosi_r;
      if (h_cs[SYNC]) begin
        if (!h_cs[SYNC+1] && m_idx == 1 && m_bits == 0) begin
          if (m_bytes[0] == 8'h06) m_wel = 1'b1;
          if (m_bytes[0] == 8'h04) m_wel = 1'b0;
        end
        m_bits = 0; m_idx = 0; m_oe = 1'b0; m_tx = 8'h00;
      end else if (h_sck[SYNC] && !h_sck[SYNC+1]) begin
        m_rx = {m_rx[6:0], h_mosi[SYNC]};
        m_bits++;
        if (m_bits == 8) begin
          if (m_idx < 16) m_bytes[m_idx] = m_rx;
          m_bits = 0;
          m_idx++;
        end
      end else if (!h_sck[SYNC] && h_sck[SYNC+1]) begin
        if (m_bits == 0 && m_idx > 0) {m_oe, m_tx} = ref_reply(m_idx);
        else if (m_bits != 0) m_tx = {m_tx[6:0], 1'b0};
      end
    end
  end

  // per-cycle comparison of the data and enable lines
  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (miso_oe_o !== m_oe || miso_o !== (m_oe & m_tx[7])) begin
        mismatched++;
        $display("FAIL R9/R10 cycle %0d: oe=%b miso=%b exp oe=%b miso=%b",
                 cyc, miso_oe_o, miso_o, m_oe, m_oe & m_tx[7]);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog: cycles=%0d exp<=%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  logic       rx_oe  [16];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_xfer(input int nbits);
    for (int i = 0; i < 16; i++) begin rx_buf[i] = 8'h00; rx_oe[i] = 1'b0; end
    cs_nr = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi_r = tx_buf[b/8][7-(b%8)];
      repeat (HALF) @(negedge clk);
      rx_buf[b/8][7-(b%8)] = miso_o;
      if (b % 8 == 0) rx_oe[b/8] = miso_oe_o;
      sck_r = 1'b1;
      repeat (HALF) @(negedge clk);
      sck_r = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_nr  = 1'b1;
    mosi_r = 1'b0;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic one_op(input logic [7:0] op, input int nbits);
    for (int i = 0; i < 16; i++) tx_buf[i] = 8'h00;
    tx_buf[0] = op;
    run_xfer(nbits);
  endtask

  task automatic read_status(input string tag, input logic wel_exp, input int nbytes);
    one_op(8'h05, 8*nbytes);
    for (int k = 1; k < nbytes; k++) begin
      chk(tag, rx_buf[k], {status_r[7:2], wel_exp, status_r[0]});
      chk({tag, " oe"}, {7'd0, rx_oe[k]}, 8'h01);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11 oe after reset", {7'd0, miso_oe_o}, 8'h00);
    status_r = 8'hA5;
    read_status("R11 latch clear after reset", 1'b0, 2);

    // R5: status bit 1 from latch, other bits pass through, streamed
    status_r = 8'hFE;
    read_status("R5 stream", 1'b0, 5);
    status_r = 8'h3D;
    read_status("R5 layout", 1'b0, 3);

    // R1, R8, R9: JEDEC identification
    one_op(8'h9F, 8*6);
    chk("R9 opcode byte quiet", {7'd0, rx_oe[0]}, 8'h00);
    chk("R1 byte1 mfr", rx_buf[1], mfr_r);
    chk("R1 byte2 type", rx_buf[2], type_r);
    chk("R1 byte3 dev", rx_buf[3], dev_r);
    chk("R8 9F byte4", rx_buf[4], 8'hFF);
    chk("R8 9F byte5", rx_buf[5], 8'hFF);

    // R2: selector 0x00
    mfr_r = 8'hEF; dev_r = 8'h4A;
    for (int i = 0; i < 16; i++) tx_buf[i] = 8'h00;
    tx_buf[0] = 8'h90; tx_buf[3] = 8'h00;
    run_xfer(8*7);
    for (int k = 1; k < 4; k++) chk("R9 90 dummy quiet", {7'd0, rx_oe[k]}, 8'h00);
    chk("R2 first mfr", rx_buf[4], mfr_r);
    chk("R2 second dev", rx_buf[5], dev_r);
    chk("R8 90 byte6", rx_buf[6], 8'hFF);

    // R3: selector 0x01 and another nonzero value
    tx_buf[3] = 8'h01;
    run_xfer(8*6);
    chk("R3 first dev", rx_buf[4], dev_r);
    chk("R3 second mfr", rx_buf[5], mfr_r);
    tx_buf[3] = 8'h80;
    run_xfer(8*6);
    chk("R3 sel80 first dev", rx_buf[4], dev_r);
    chk("R3 sel80 second mfr", rx_buf[5], mfr_r);

    // R4: signature read
    dev_r = 8'h13;
    for (int i = 0; i < 16; i++) tx_buf[i] = 8'h5A;
    tx_buf[0] = 8'hAB;
    run_xfer(8*6);
    for (int k = 1; k < 4; k++) chk("R9 AB dummy quiet", {7'd0, rx_oe[k]}, 8'h00);
    chk("R4 fifth byte dev", rx_buf[4], dev_r);
    chk("R8 AB byte5", rx_buf[5], 8'hFF);

    // R6, R7: write-enable latch
    status_r = 8'h00;
    one_op(8'h06, 7);
    read_status("R7 wren 7 bits ignored", 1'b0, 2);
    one_op(8'h06, 9);
    read_status("R7 wren 9 bits ignored", 1'b0, 2);
    one_op(8'h06, 8);
    read_status("R6 wren sets latch", 1'b1, 3);
    one_op(8'h04, 16);
    read_status("R7 wrdi 16 bits ignored", 1'b1, 2);
    one_op(8'h04, 8);
    read_status("R6 wrdi clears latch", 1'b0, 2);
    one_op(8'h06, 8);
    one_op(8'h06, 8);
    read_status("R6 wren twice", 1'b1, 2);

    // R9: commands without reply
    one_op(8'h06, 8*3);
    for (int k = 0; k < 3; k++) chk("R9 wren no drive", {7'd0, rx_oe[k]}, 8'h00);
    one_op(8'h3C, 8*3);
    for (int k = 0; k < 3; k++) chk("R9 unknown no drive", {7'd0, rx_oe[k]}, 8'h00);
    read_status("R7 long wren ignored", 1'b1, 2);

    // R10: aborted frame mid-byte, then a clean frame
    one_op(8'h9F, 13);
    one_op(8'h9F, 8*2);
    chk("R10 after abort mfr", rx_buf[1], mfr_r);

    repeat (10) @(negedge clk);
    summary();
  end

endmodule